// File: doc/BRIEF.md
# Parity-Protected Data Buffer With Poison

This block is a small dual-port storage buffer for transfer data. Each entry holds a data word, one even-parity bit for each byte lane, and a poison flag. The parity bits are computed at write time for every entry, including entries whose data is already known to be bad. A write may carry an uncorrectable indication from an upstream checker, such as a double-bit ECC error or a parity failure on the private data path. Such a word is stored with correct parity and its poison flag set.

On a read, the parity of the stored data is computed again and compared with the stored bits. A mismatch means the entry was corrupted while it sat in the buffer. It is reported on a separate internal-error output. Poisoned data is passed out with its flag and does not raise that error by itself. This lets a consumer tell upstream damage apart from damage inside the buffer.

Reads and writes use independent addresses. A read returns its result one cycle after the request. A fault-injection input can invert the generated parity bit of one chosen lane as a write happens, so the error path can be exercised.

Top module: `pbuf_top`

## Requirements
- R1: While rst_ni is low and after its release, rd_valid_o is low, and every entry reads back as all-zero data with rd_poison_o and rd_par_err_o low.
- R2: A read requested with rd_en_i in cycle N presents rd_valid_o high with its result in cycle N+1. Without a request, rd_valid_o is low in the next cycle, and rd_poison_o and rd_par_err_o are low whenever rd_valid_o is low.
- R3: Data written to an entry is returned unchanged by later reads of that entry, and writes to one entry leave all other entries unchanged.
- R4: One even-parity bit is generated per 8-bit lane, with lane k being data bits 8k+7 down to 8k. An entry written without injection reads back with rd_par_err_o low.
- R5: A write with wr_uncorr_i high stores the word with correct parity and the poison flag set. Reading it gives rd_poison_o high and rd_par_err_o low.
- R6: Overwriting a poisoned entry with a write whose wr_uncorr_i is low clears its poison flag.
- R7: A write with inj_en_i high inverts the stored parity bit of lane inj_lane_i. Reading that entry raises rd_par_err_o, returns the written data unchanged, and leaves rd_poison_o equal to the written wr_uncorr_i.
- R8: Injection into any single lane, 0 through 7, is detected on read.
- R9: An entry written both poisoned and with injection reads back with rd_poison_o and rd_par_err_o both high.
- R10: A read and a write to the same entry in the same cycle return the entry's previous contents. The next read of that entry returns the new contents.
- R11: inj_en_i has no effect in a cycle where wr_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 4 | Write entry index |
| wr_data_i | input | 64 | Write data |
| wr_uncorr_i | input | 1 | Upstream uncorrectable-error flag for the write data |
| inj_en_i | input | 1 | Invert one generated parity bit on this write |
| inj_lane_i | input | 3 | Lane whose parity bit is inverted |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 4 | Read entry index |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Read data |
| rd_poison_o | output | 1 | Entry carries upstream poison |
| rd_par_err_o | output | 1 | Stored parity mismatch (corruption inside the buffer) |

## Verification
The bench builds the block with its defaults: a 64-bit word split into eight byte lanes and 16 entries. With these values a run can reach every entry and inject into every lane. The lane sweep spreads injections over eight different entries, so a fault is caught only if it lands in the right lane of the right entry. The small depth also allows whole-buffer sweeps after reset and after a fill with distinct patterns. These sweeps expose aliasing between addresses as well as the same-cycle read and write case.

// File: rtl/pbuf_pkg.sv
`timescale 1ns/1ps
package pbuf_pkg;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/pbuf_par_gen.sv
`timescale 1ns/1ps
module pbuf_par_gen #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned NL = DATA_W / pbuf_pkg::LANE_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [NL-1:0]     par_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign par_o[g] = ^data_i[g*pbuf_pkg::LANE_W +: pbuf_pkg::LANE_W];
  end
endmodule

// File: rtl/pbuf_store.sv
`timescale 1ns/1ps
module pbuf_store #(
  parameter int unsigned W     = 73,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else begin
      // read sees contents from before this cycle's write
      if (re_i) rdata_o <= mem_q[raddr_i];
      if (we_i) mem_q[waddr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/pbuf_top.sv
`timescale 1ns/1ps
module pbuf_top #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned NL    = DATA_W / pbuf_pkg::LANE_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = $clog2(NL),
  localparam int unsigned EW    = DATA_W + NL + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_uncorr_i,
  input  logic              inj_en_i,
  input  logic [LW-1:0]     inj_lane_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_poison_o,
  output logic              rd_par_err_o
);
  logic [NL-1:0] wr_par, inj_mask, rd_par_calc, rd_par_stored;
  logic [EW-1:0] wr_word, rd_word;
  logic          rd_valid_q;

  pbuf_par_gen #(.DATA_W(DATA_W)) u_gen (.data_i(wr_data_i), .par_o(wr_par));

  assign inj_mask = inj_en_i ? (NL'(1) << inj_lane_i) : '0;
  assign wr_word  = {wr_uncorr_i, wr_par ^ inj_mask, wr_data_i};

  pbuf_store #(.W(EW), .DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_word),
    .re_i   (rd_en_i),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= rd_en_i;
  end

  assign rd_data_o     = rd_word[DATA_W-1:0];
  assign rd_par_stored = rd_word[DATA_W +: NL];

  pbuf_par_gen #(.DATA_W(DATA_W)) u_chk (.data_i(rd_data_o), .par_o(rd_par_calc));

  assign rd_valid_o   = rd_valid_q;
  assign rd_poison_o  = rd_valid_q & rd_word[EW-1];
  assign rd_par_err_o = rd_valid_q & (|(rd_par_calc ^ rd_par_stored));

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (!rd_poison_o && !rd_par_err_o));

  assert_clean_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && $past(wr_en_i && !inj_en_i) && rd_addr_i == $past(wr_addr_i))
    |=> !rd_par_err_o);

  assert_poison_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && $past(wr_en_i) && rd_addr_i == $past(wr_addr_i))
    |=> (rd_poison_o == $past(wr_uncorr_i, 2)));

  assert_inject_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && $past(wr_en_i && inj_en_i) && rd_addr_i == $past(wr_addr_i))
    |=> rd_par_err_o);
endmodule

// File: tb/sim_pbuf_top.sv
`timescale 1ns/1ps
module sim_pbuf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_uncorr = 1'b0, inj_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [2:0]  inj_lane = '0;
  logic [63:0] wr_data = '0;
  logic        rd_valid, rd_poison, rd_par_err;
  logic [63:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] d;
    bit          p;
    bit          e;
    string       tag;
  } item_t;
  item_t q[$];

  logic [63:0] m_data [16];
  bit          m_pois [16];
  bit          m_err  [16];

  always #2.5 clk = ~clk;

  pbuf_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_uncorr_i(wr_uncorr),
    .inj_en_i(inj_en), .inj_lane_i(inj_lane),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_poison_o(rd_poison), .rd_par_err_o(rd_par_err)
  );

  function automatic logic [63:0] pat(input int i);
    return 64'h0123_4567_89AB_CDEF ^ {16{4'(i)}} ^ (64'h1 << (i * 3));
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(input bit we, input int wa, input logic [63:0] wd, input bit unc,
                    input bit inj, input int lane, input bit re, input int ra, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = 4'(wa); wr_data = wd; wr_uncorr = unc;
    inj_en = inj; inj_lane = 3'(lane);
    rd_en = re; rd_addr = 4'(ra);
    if (re) q.push_back('{m_data[ra], m_pois[ra], m_err[ra], tag});
    if (we) begin
      m_data[wa] = wd; m_pois[wa] = unc; m_err[wa] = inj;
    end
  endtask

  task automatic rd(input int a, input string tag);
    op(0, 0, '0, 0, 0, 0, 1, a, tag);
  endtask

  task automatic wr(input int a, input logic [63:0] d, input bit unc, input bit inj, input int lane, input string tag);
    op(1, a, d, unc, inj, lane, 0, 0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, '0, 0, 0, 0, 0, 0, "idle");
  endtask

  // monitor: pops expected read results one cycle after each request
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rd_valid) begin
        if (q.size() == 0) chk("R2", "unexpected valid", 64'(rd_valid), 64'd0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(it.tag, "data", rd_data, it.d);
          chk(it.tag, "poison", 64'(rd_poison), 64'(it.p));
          chk(it.tag, "par_err", 64'(rd_par_err), 64'(it.e));
        end
      end else if (q.size() != 0) begin
        chk("R2", "missing valid", 64'(rd_valid), 64'd1);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_data[i] = '0; m_pois[i] = 0; m_err[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid in reset", 64'(rd_valid), 64'd0);
    chk("R1", "flags in reset", 64'({rd_poison, rd_par_err}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "valid after release", 64'(rd_valid), 64'd0);

    for (int i = 0; i < 16; i++) rd(i, "R1");
    idle(2);
    @(posedge clk); #1;
    chk("R2", "idle valid", 64'(rd_valid), 64'd0);
    chk("R2", "idle flags", 64'({rd_poison, rd_par_err}), 64'd0);

    // fill, then read back out of order
    for (int i = 0; i < 16; i++) wr(i, pat(i), 0, 0, 0, "R3");
    for (int i = 15; i >= 0; i--) rd(i, "R3");
    for (int i = 0; i < 16; i += 5) rd(i, "R4");

    // poison and its clearing
    wr(3, 64'hFFFF_0000_FFFF_0000, 1, 0, 0, "R5");
    wr(7, 64'h8000_0000_0000_0001, 1, 0, 0, "R5");
    rd(3, "R5"); rd(7, "R5"); rd(6, "R3");
    wr(3, 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 0, "R6");
    rd(3, "R6"); rd(7, "R5");

    // fault injection on each lane, one entry per lane
    for (int k = 0; k < 8; k++) wr(8 + k, pat(k) ^ 64'hA5, 0, 1, k, "R7");
    for (int k = 0; k < 8; k++) rd(8 + k, "R8");
    rd(7, "R7");

    // poisoned and corrupted together
    wr(5, 64'h1234_5678_9ABC_DEF0, 1, 1, 6, "R9");
    rd(5, "R9");

    // same-cycle read and write to one entry
    op(1, 2, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 1, 2, "R10");
    rd(2, "R10");

    // injection request with no write
    op(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2, 0, 0, "R11");
    rd(0, "R11");
    wr(9, pat(9), 0, 0, 0, "R6");
    rd(9, "R4");

    idle(3);
    chk("R2", "queue drained", 64'(q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule